// File: doc/BRIEF.md
# Almost-Flag Offset Loader

This block supplies the almost-empty offset (X) and the almost-full offset (Y) that a FIFO's flag comparators use. It decides how those two values get set from a program-mode pin and a two-bit flag-select field. The block captures both at the last clock edge on which master reset is still asserted. With program-mode high and a nonzero flag-select, both offsets take one of three fixed presets and programming is over at once. With program-mode high and flag-select zero, the block waits for data. The first two accepted writes on the parallel input port are held back from the FIFO memory and load Y, then X. Only after that does it let writes through to storage.

Around this block the FIFO sees three things. The first is an input-ready signal that rises two clock edges after every reset, so the programming writes can be accepted. The second is a store enable that tells the memory whether the current write is data. The third is a done flag that marks the start of normal operation. Partial reset only restarts the input-ready sequence. The offsets, the latched mode and any programming already done are kept.

Top module: `ofp_offset_prog`

## Requirements
- R1: While mrst_n is low, in_ready and wr_store are low. After the first clock edge in reset, prog_done is low.
- R2: After the release of master or partial reset, in_ready goes high after the second rising edge at which both resets are high, and stays high until a reset is asserted again. in_ready is low in any cycle in which either reset input is low.
- R3: cfg_prog and cfg_fsel are captured at the last rising edge with mrst_n low. Changing them afterwards has no effect on the offsets, the store enable or the done flag.
- R4: With cfg_prog=1 and cfg_fsel=2'b11, off_x and off_y both equal 64 (parameter PRESET_HI). prog_done rises after the first rising edge following release.
- R5: With cfg_prog=1, cfg_fsel=2'b01 gives 16 (PRESET_LO) and cfg_fsel=2'b10 gives 8 (PRESET_MID) on both offsets.
- R6: In parallel mode (cfg_prog=1, cfg_fsel=2'b00), the first accepted write (wr_en and in_ready high at a rising edge) loads off_y from wr_data[OW-1:0], with wr_data[OW-1] as MSB. wr_store is low for that write.
- R7: The second accepted write in parallel mode loads off_x from wr_data[OW-1:0] with wr_store low. prog_done is high from the following cycle.
- R8: A write strobe while in_ready is low neither loads an offset nor advances the programming step.
- R9: Once prog_done is high, wr_store equals wr_en and in_ready, further writes leave both offsets unchanged, and prog_done stays high until master reset.
- R10: Partial reset (prst_n low) leaves off_x, off_y, prog_done and the programming step unchanged.
- R11: With cfg_prog=0, both offsets are 0 and prog_done rises after the first rising edge following release.
- R12: Data bits at and above OW are ignored. An all-ones low field loads 4095 for OW=12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mrst_n | input | 1 | Master reset, active low, sampled on the clock |
| prst_n | input | 1 | Partial reset, active low, sampled on the clock |
| cfg_prog | input | 1 | Program-mode select, captured during master reset |
| cfg_fsel | input | 2 | Flag-select field, captured during master reset |
| wr_en | input | 1 | Write strobe from the input port |
| wr_data | input | DW | Input port data |
| off_x | output | OW | Almost-empty offset |
| off_y | output | OW | Almost-full offset |
| wr_store | output | 1 | Current write goes into FIFO memory |
| in_ready | output | 1 | Input ready, writes are accepted |
| prog_done | output | 1 | Offsets loaded, normal operation |

## Verification
A partial reset and a programming write can fall on the same clock edge. The bench holds wr_en high with fresh data in the same cycles in which prst_n is driven low, while the Y value is loaded and X is still pending. The reference model requires that the strobe is discarded. So off_x must keep its old value, the following write must still be taken as the X load, and off_y must stay untouched throughout. A write strobe in the first cycle after master reset release, before in_ready rises, is provoked and judged the same way.

// File: rtl/ofp_pkg.sv
package ofp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WAIT_Y = 2'd1,
    ST_WAIT_X = 2'd2,
    ST_DONE   = 2'd3
  } ofp_state_e;

  typedef enum logic [1:0] {
    SRC_ZERO     = 2'd0,
    SRC_PRESET   = 2'd1,
    SRC_PARALLEL = 2'd2
  } ofp_src_e;

  // How the offsets are sourced, from the program-mode bit and flag-select.
  function automatic ofp_src_e src_of(input logic prog, input logic [1:0] fsel);
    if (!prog)          return SRC_ZERO;
    else if (fsel == 0) return SRC_PARALLEL;
    else                return SRC_PRESET;
  endfunction

  // Preset picked by a nonzero flag-select code.
  function automatic int unsigned preset_value(input logic [1:0] fsel,
                                               input int unsigned p_lo,
                                               input int unsigned p_mid,
                                               input int unsigned p_hi);
    case (fsel)
      2'b01:   return p_lo;
      2'b10:   return p_mid;
      2'b11:   return p_hi;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/ofp_mode_latch.sv
module ofp_mode_latch (
  input  logic       clk,
  input  logic       mrst_n,
  input  logic       pin_prog,
  input  logic [1:0] pin_fsel,
  output logic       lat_prog,
  output logic [1:0] lat_fsel
);
  // Follows the pins while master reset is held; frozen afterwards.
  always_ff @(posedge clk) begin
    if (!mrst_n) begin
      lat_prog <= pin_prog;
      lat_fsel <= pin_fsel;
    end
  end
endmodule

// File: rtl/ofp_ready_seq.sv
module ofp_ready_seq #(
  parameter int unsigned READY_DLY = 2
) (
  input  logic clk,
  input  logic mrst_n,
  input  logic prst_n,
  output logic in_ready
);
  localparam int unsigned CW = $clog2(READY_DLY + 1);
  localparam logic [CW-1:0] CMAX = CW'(READY_DLY);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!mrst_n || !prst_n)  cnt_q <= '0;
    else if (cnt_q != CMAX)  cnt_q <= cnt_q + 1'b1;
  end

  // Gated by the live reset pins so a write on a reset edge is never taken.
  assign in_ready = (cnt_q == CMAX) && mrst_n && prst_n;
endmodule

// File: rtl/ofp_offset_ctrl.sv
module ofp_offset_ctrl
  import ofp_pkg::*;
#(
  parameter int unsigned DW        = 16,
  parameter int unsigned OW        = 12,
  parameter int unsigned PRESET_LO  = 16,
  parameter int unsigned PRESET_MID = 8,
  parameter int unsigned PRESET_HI  = 64
) (
  input  logic          clk,
  input  logic          mrst_n,
  input  logic          pin_prog,
  input  logic [1:0]    pin_fsel,
  input  logic          lat_prog,
  input  logic [1:0]    lat_fsel,
  input  logic          acc_wr,
  input  logic [DW-1:0] wr_data,
  output logic [OW-1:0] off_x,
  output logic [OW-1:0] off_y,
  output logic          prog_done,
  output logic          y_load_evt,
  output logic          x_load_evt
);
  localparam int unsigned NSLOT = 2;   // slot 0 = Y (loaded first), slot 1 = X

  ofp_state_e st_q, st_d;
  logic [OW-1:0] init_val;
  logic [OW-1:0] wr_field;
  logic [OW-1:0] slot_q  [NSLOT];
  logic [NSLOT-1:0] slot_ld;

  assign wr_field = wr_data[OW-1:0];
  assign init_val = (src_of(pin_prog, pin_fsel) == SRC_PRESET)
                  ? OW'(preset_value(pin_fsel, PRESET_LO, PRESET_MID, PRESET_HI))
                  : '0;

  assign slot_ld[0] = acc_wr && (st_q == ST_WAIT_Y);
  assign slot_ld[1] = acc_wr && (st_q == ST_WAIT_X);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:   st_d = (src_of(lat_prog, lat_fsel) == SRC_PARALLEL) ? ST_WAIT_Y : ST_DONE;
      ST_WAIT_Y: if (acc_wr) st_d = ST_WAIT_X;
      ST_WAIT_X: if (acc_wr) st_d = ST_DONE;
      default:   st_d = ST_DONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!mrst_n) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!mrst_n)         slot_q[i] <= init_val;
      else if (slot_ld[i]) slot_q[i] <= wr_field;
    end
  end

  assign off_y      = slot_q[0];
  assign off_x      = slot_q[1];
  assign prog_done  = (st_q == ST_DONE);
  assign y_load_evt = slot_ld[0];
  assign x_load_evt = slot_ld[1];
endmodule

// File: rtl/ofp_offset_prog.sv
module ofp_offset_prog #(
  parameter int unsigned DW         = 16,
  parameter int unsigned OW         = 12,
  parameter int unsigned PRESET_LO  = 16,
  parameter int unsigned PRESET_MID = 8,
  parameter int unsigned PRESET_HI  = 64,
  parameter int unsigned READY_DLY  = 2
) (
  input  logic          clk,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  logic          cfg_prog,
  input  logic [1:0]    cfg_fsel,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [OW-1:0] off_x,
  output logic [OW-1:0] off_y,
  output logic          wr_store,
  output logic          in_ready,
  output logic          prog_done
);
  logic       lat_prog;
  logic [1:0] lat_fsel;
  logic       acc_wr;
  logic       y_load_evt;
  logic       x_load_evt;

  ofp_mode_latch u_latch (
    .clk      (clk),
    .mrst_n   (mrst_n),
    .pin_prog (cfg_prog),
    .pin_fsel (cfg_fsel),
    .lat_prog (lat_prog),
    .lat_fsel (lat_fsel)
  );

  ofp_ready_seq #(.READY_DLY(READY_DLY)) u_ready (
    .clk      (clk),
    .mrst_n   (mrst_n),
    .prst_n   (prst_n),
    .in_ready (in_ready)
  );

  assign acc_wr = wr_en && in_ready;

  ofp_offset_ctrl #(
    .DW(DW), .OW(OW),
    .PRESET_LO(PRESET_LO), .PRESET_MID(PRESET_MID), .PRESET_HI(PRESET_HI)
  ) u_ctrl (
    .clk        (clk),
    .mrst_n     (mrst_n),
    .pin_prog   (cfg_prog),
    .pin_fsel   (cfg_fsel),
    .lat_prog   (lat_prog),
    .lat_fsel   (lat_fsel),
    .acc_wr     (acc_wr),
    .wr_data    (wr_data),
    .off_x      (off_x),
    .off_y      (off_y),
    .prog_done  (prog_done),
    .y_load_evt (y_load_evt),
    .x_load_evt (x_load_evt)
  );

  assign wr_store = acc_wr && prog_done;
endmodule

// File: rtl/ofp_checker.sv
module ofp_checker #(
  parameter int unsigned DW = 16,
  parameter int unsigned OW = 12
) (
  input logic          clk,
  input logic          mrst_n,
  input logic          prst_n,
  input logic [DW-1:0] wr_data,
  input logic [OW-1:0] off_x,
  input logic [OW-1:0] off_y,
  input logic          in_ready,
  input logic          prog_done,
  input logic          y_load_evt,
  input logic          x_load_evt,
  input logic          lat_prog,
  input logic [1:0]    lat_fsel
);
  // R6
  y_load_data_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    y_load_evt |=> (off_y == $past(wr_data[OW-1:0])));

  // R7
  x_load_done_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    x_load_evt |=> (prog_done && off_x == $past(wr_data[OW-1:0])));

  // R9
  done_sticky_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    prog_done |=> prog_done);

  // R10
  prst_keeps_offsets_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    !prst_n |=> ($stable(off_x) && $stable(off_y)));

  // R3
  mode_frozen_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    $past(mrst_n) |-> ($stable(lat_prog) && $stable(lat_fsel)));

  // R2
  ready_after_reset_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    $rose(in_ready) |-> ($past(mrst_n) && $past(prst_n)));
endmodule

bind ofp_offset_prog ofp_checker #(.DW(DW), .OW(OW)) u_chk (
  .clk        (clk),
  .mrst_n     (mrst_n),
  .prst_n     (prst_n),
  .wr_data    (wr_data),
  .off_x      (off_x),
  .off_y      (off_y),
  .in_ready   (in_ready),
  .prog_done  (prog_done),
  .y_load_evt (y_load_evt),
  .x_load_evt (x_load_evt),
  .lat_prog   (lat_prog),
  .lat_fsel   (lat_fsel)
);

// File: tb/tb_ofp_offset_prog.sv
`timescale 1ns/1ps
module tb_ofp_offset_prog;
  logic        clk = 1'b0;
  logic        mrst_n = 1'b0;
  logic        prst_n = 1'b1;
  logic        cfg_prog = 1'b0;
  logic [1:0]  cfg_fsel = 2'b00;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [11:0] off_x, off_y;
  logic        wr_store, in_ready, prog_done;

  always #4 clk = ~clk;   // 125 MHz

  ofp_offset_prog dut (
    .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .cfg_prog(cfg_prog),
    .cfg_fsel(cfg_fsel), .wr_en(wr_en), .wr_data(wr_data), .off_x(off_x),
    .off_y(off_y), .wr_store(wr_store), .in_ready(in_ready), .prog_done(prog_done)
  );

  int checks = 0;
  int errors = 0;
  bit started = 0;
  bit finished = 0;
  string tag = "R1";

  // Reference model state: step 0 idle, 1 expect Y, 2 expect X, 3 done.
  int m_cnt = 0, m_step = 0, m_x = 0, m_y = 0;
  bit m_prog = 0;
  int m_fsel = 0;

  function automatic int exp_preset(input bit prog, input int fs);
    if (!prog) return 0;
    if (fs == 3) return 64;
    if (fs == 1) return 16;
    if (fs == 2) return 8;
    return 0;
  endfunction

  function automatic bit m_ready();
    return (m_cnt >= 2) && mrst_n && prst_n;
  endfunction

  always @(posedge clk) begin : model
    bit rdy;
    rdy = m_ready();
    started = 1;
    if (!mrst_n) begin
      m_prog = cfg_prog; m_fsel = int'(cfg_fsel);
      m_cnt = 0; m_step = 0;
      m_x = exp_preset(cfg_prog, int'(cfg_fsel)); m_y = m_x;
    end else begin
      if (m_step == 0) m_step = (m_prog && m_fsel == 0) ? 1 : 3;
      else if (wr_en && rdy && m_step == 1) begin m_y = int'(wr_data) % 4096; m_step = 2; end
      else if (wr_en && rdy && m_step == 2) begin m_x = int'(wr_data) % 4096; m_step = 3; end
      if (!prst_n) m_cnt = 0; else if (m_cnt < 2) m_cnt++;
    end
  end

  task automatic chk(input bit ok, input string t, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
    end
  endtask

  task automatic compare();
    bit er, ed, es;
    if (!started) return;
    er = m_ready();
    ed = (m_step == 3);
    es = wr_en && er && ed;
    chk(in_ready == er && prog_done == ed && wr_store == es &&
        int'(off_x) == m_x && int'(off_y) == m_y, tag,
        {in_ready, prog_done, wr_store} * 100000 + int'(off_x) * 0 + int'(off_y),
        {er, ed, es} * 100000 + m_y);
    if (int'(off_x) != m_x) $display("FAIL %s off_x actual=%0d expected=%0d", tag, off_x, m_x);
  endtask

  task automatic cyc(input bit we, input logic [15:0] d);
    wr_en = we; wr_data = d;
    #1 compare();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input bit prog, input logic [1:0] fs);
    tag = "R1";
    mrst_n = 1'b0; cfg_prog = prog; cfg_fsel = fs;
    repeat (4) cyc(1'b1, 16'hFFFF);
    chk(!in_ready && !wr_store && !prog_done, "R1 quiet in reset",
        {in_ready, wr_store, prog_done}, 0);
    mrst_n = 1'b1;
  endtask

  initial begin
    @(negedge clk);
    // Preset 64, then change pins after release (R3, R4)
    do_reset(1'b1, 2'b11);
    tag = "R2"; cyc(0, 0);
    chk(prog_done, "R4 done after first edge", prog_done, 1);
    chk(!in_ready, "R2 not ready after one edge", in_ready, 0);
    cfg_prog = 1'b1; cfg_fsel = 2'b00;
    cyc(0, 0);
    chk(in_ready, "R2 ready after two edges", in_ready, 1);
    chk(off_x == 64 && off_y == 64, "R4 preset 64", off_x, 64);
    tag = "R9"; cyc(1, 16'h0123); cyc(1, 16'h0456);
    chk(off_y == 64 && off_x == 64, "R3 R9 offsets held after pin change", off_y, 64);

    do_reset(1'b1, 2'b01); tag = "R5"; repeat (3) cyc(0, 0);
    chk(off_x == 16 && off_y == 16, "R5 preset lo", off_x, 16);
    do_reset(1'b1, 2'b10); tag = "R5"; repeat (3) cyc(0, 0);
    chk(off_x == 8 && off_y == 8, "R5 preset mid", off_x, 8);
    do_reset(1'b0, 2'b11); tag = "R11"; repeat (3) cyc(0, 0);
    chk(off_x == 0 && off_y == 0 && prog_done, "R11 zero offsets done", off_x, 0);

    // Parallel programming
    do_reset(1'b1, 2'b00);
    tag = "R8"; cyc(1, 16'h0AAA);   // not ready yet
    cyc(0, 0);
    chk(off_y == 0 && !prog_done, "R8 early strobe ignored", off_y, 0);
    tag = "R6"; wr_en = 1; wr_data = 16'hF123; #1;
    chk(!wr_store, "R6 Y write not stored", wr_store, 0);
    cyc(1, 16'hF123);
    chk(off_y == 12'h123, "R6 R12 Y from low bits", off_y, 12'h123);
    tag = "R10"; prst_n = 1'b0;
    cyc(1, 16'h0555); cyc(1, 16'h0666);
    prst_n = 1'b1; cyc(1, 16'h0777); cyc(0, 0);
    chk(off_x == 0 && off_y == 12'h123 && !prog_done, "R10 prst with strobe discarded", off_x, 0);
    tag = "R7"; cyc(1, 16'hFFFF);
    chk(off_x == 12'hFFF && prog_done, "R7 R12 X loaded 4095", off_x, 4095);
    tag = "R9"; wr_en = 1; #1;
    chk(wr_store, "R9 normal store", wr_store, 1);
    cyc(1, 16'h0001); cyc(0, 0);
    chk(off_x == 12'hFFF && off_y == 12'h123, "R9 offsets unchanged", off_x, 4095);
    tag = "R10"; prst_n = 1'b0; cyc(0, 0); cyc(0, 0); prst_n = 1'b1;
    cyc(0, 0); cyc(0, 0);
    chk(prog_done && in_ready && off_x == 12'hFFF && off_y == 12'h123,
        "R10 offsets kept after partial reset", off_y, 12'h123);
    cyc(0, 0);
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1600000;
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule